// File: doc/BRIEF.md
# Dual-Bank Byte/Word Access Sequencer

This block sits between a CPU-side access port and a 16-bit memory that is built from two byte-wide banks. The even bank holds the bytes at even addresses on data lines 7:0. The odd bank holds the bytes at odd addresses on lines 15:8. A request carries a byte address, a byte-or-word size and a direction. The block runs one or two bus cycles to serve it. Each bus cycle is a simple handshake: the block raises `bus_req` and holds every bus output steady until the memory side answers with `bus_rdy`.

The word address (address bits above bit 0) goes to both banks at once. The lowest address bit `bus_a0` enables the even bank when it is low. The active-low `bus_bhe_n` enables the odd bank. Write bytes are placed on the lane of the bank that takes them. Read bytes are gathered from the right lane and returned right-justified. A word at an odd address is split into two bus cycles, and the two lanes are swapped between them.

An external bus master may ask for the bus through a hold request. The grant is only given while the sequencer is idle, and never between the two halves of a split word.

Top module: `dual_bank_seq`

## Requirements
- R1: While reset is asserted and just after it, `bus_req`, `busy`, `done` and `hold_ack` are 0 and `req_ready` is 1.
- R2: A byte access to an even address X runs one bus cycle with word address X[19:1], `bus_a0`=0 and `bus_bhe_n`=1. A read returns {8'h00, lines 7:0}.
- R3: A byte access to an odd address X runs one bus cycle with word address X[19:1], `bus_a0`=1 and `bus_bhe_n`=0. A read returns {8'h00, lines 15:8}.
- R4: A word access to an even address X runs one bus cycle with `bus_a0`=0 and `bus_bhe_n`=0. A read returns all 16 lines, with the byte at X in bits 7:0.
- R5: A word access to an odd address X runs two bus cycles:
  - First cycle: word address X[19:1], `bus_a0`=1, `bus_bhe_n`=0.
  - Second cycle: word address X[19:1]+1, `bus_a0`=0, `bus_bhe_n`=1.
  - A read returns {second cycle lines 7:0, first cycle lines 15:8}.
- R6: On writes, `bus_we` is 1 in every bus cycle, and the data is placed as follows:
  - Aligned word: the write word unchanged.
  - Byte write: the data byte on both lanes.
  - Split word, first cycle: the low data byte on both lanes.
  - Split word, second cycle: the high data byte on both lanes.
- R7: `done` is a one-cycle pulse in the cycle after the edge where the final `bus_rdy` is sampled. `rdata` is updated only by reads, so a write leaves it at the previous read result.
- R8: While `bus_req` is 1, `bus_a0`=1 together with `bus_bhe_n`=1 is never driven.
- R9: While `bus_req` is 1 and `bus_rdy` is 0, all bus outputs keep their values into the next cycle.
- R10: When `hold_req` is seen high while idle and no request is taken, `hold_ack` rises one cycle later. It falls one cycle after `hold_req` drops. While `hold_ack` is 1, `req_ready` is 0 and requests are ignored.
- R11: `busy` stays 1 from the cycle after a request is taken through its last bus cycle, without a gap between the two halves of a split word. `hold_ack` is never 1 while `busy` is 1.
- R12: A request and a hold request that arrive in the same idle cycle: the request is taken and the grant waits until the request is done.
- R13: A split word at the top address wraps its second cycle to word address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| req_ready | output | 1 | Request is taken when this and req_valid are both high |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, right-justified |
| busy | output | 1 | Access in progress; no hold grant while high |
| bus_req | output | 1 | Bus cycle active |
| bus_addr | output | 19 | Word address to both banks |
| bus_a0 | output | 1 | Address bit 0; low enables the even bank |
| bus_bhe_n | output | 1 | Low enables the odd bank |
| bus_we | output | 1 | Bus cycle is a write |
| bus_wdata | output | 16 | Write lanes |
| bus_rdata | input | 16 | Read lanes |
| bus_rdy | input | 1 | Ends the current bus cycle |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus granted to the external master |

## Verification
Two functions can fall in the same cycle:
- A CPU request and a hold request arriving together in an idle cycle.
- A hold request that is held high across the boundary between the two halves of a split word.

The bench raises `hold_req` in the very cycle it presents a request, and keeps it high through every wait state of both halves. During that time it judges that `busy` stays high and `hold_ack` stays low. After `done`, it checks that the grant appears one cycle later. It then checks that a request offered during the grant is not taken.

// File: rtl/dual_bank_seq.sv
module dual_bank_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              busy,
  output logic              bus_req,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              bus_a0,
  output logic              bus_bhe_n,
  output logic              bus_we,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_rdy,
  input  logic              hold_req,
  output logic              hold_ack
);
  localparam int WA_W = ADDR_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} st_t;
  st_t st;

  logic [ADDR_W-1:0] addr_q;
  logic              word_q, we_q;
  logic [15:0]       wdata_q;
  logic [7:0]        lo_q;

  wire accept = (st == S_IDLE) && !hold_ack && req_valid;
  wire split  = word_q && addr_q[0];
  wire [15:0] first_rd = word_q ? bus_rdata
                       : {8'h00, addr_q[0] ? bus_rdata[15:8] : bus_rdata[7:0]};

  assign req_ready = (st == S_IDLE) && !hold_ack;
  assign bus_req   = (st != S_IDLE);
  assign busy      = bus_req;
  assign bus_we    = bus_req && we_q;
  assign bus_addr  = (st == S_SECOND) ? addr_q[ADDR_W-1:1] + WA_W'(1) : addr_q[ADDR_W-1:1];
  assign bus_a0    = (st == S_FIRST) && addr_q[0];
  assign bus_bhe_n = (st == S_FIRST) ? !(word_q || addr_q[0]) : 1'b1;

  always_comb begin
    if (st == S_FIRST && word_q && !addr_q[0]) bus_wdata = wdata_q;
    else if (st == S_SECOND)                   bus_wdata = {wdata_q[15:8], wdata_q[15:8]};
    else                                       bus_wdata = {wdata_q[7:0], wdata_q[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      word_q   <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      lo_q     <= '0;
      rdata    <= '0;
      done     <= 1'b0;
      hold_ack <= 1'b0;
    end else begin
      done     <= 1'b0;
      hold_ack <= hold_req && (hold_ack || (st == S_IDLE && !accept));
      case (st)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr;
          word_q  <= req_word;
          we_q    <= req_write;
          wdata_q <= req_wdata;
          st      <= S_FIRST;
        end
        S_FIRST: if (bus_rdy) begin
          if (split) begin
            lo_q <= bus_rdata[15:8];
            st   <= S_SECOND;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
            if (!we_q) rdata <= first_rd;
          end
        end
        S_SECOND: if (bus_rdy) begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (!we_q) rdata <= {bus_rdata[7:0], lo_q};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  lane_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !(bus_a0 && bus_bhe_n));

  // R9
  wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_a0)
                            && $stable(bus_bhe_n) && $stable(bus_wdata) && $stable(bus_we));

  // R5
  split_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_rdy && bus_a0 && word_q |=> bus_req && !bus_a0 && !bus_bhe_n == 1'b0);

  // R11
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_ack && busy));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack && !hold_req |=> !hold_ack);
endmodule

// File: tb/sim_dual_bank_seq.sv
`timescale 1ns/1ps
module sim_dual_bank_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_write, req_word, req_ready, done, busy;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, rdata, bus_wdata, bus_rdata;
  logic bus_req, bus_a0, bus_bhe_n, bus_we, bus_rdy, hold_req, hold_ack;
  logic [18:0] bus_addr;

  dual_bank_seq #(.ADDR_W(20)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .busy(busy),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .hold_req(hold_req), .hold_ack(hold_ack));

  int checks = 0, errors = 0;
  logic [15:0] last_rd = 16'h0;

  function automatic logic [7:0] mem_byte(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_read(bit wd, logic [19:0] a);
    return wd ? {mem_byte(a + 20'd1), mem_byte(a)} : {8'h00, mem_byte(a)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(bit wr, bit wd, logic [19:0] a, logic [15:0] wdat,
                     int maxwait, bit hold, string tag);
    string tg;
    int ncyc;
    logic [18:0] ea;
    logic [15:0] ew;
    tg = (tag != "") ? tag : (wd ? (a[0] ? "R5" : "R4") : (a[0] ? "R3" : "R2"));
    ncyc = (wd && a[0]) ? 2 : 1;
    @(negedge clk);
    chk("R10", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat;
    hold_req = hold;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      int w;
      ea = (c == 0) ? a[19:1] : a[19:1] + 19'd1;
      if (wd && !a[0]) ew = wdat;
      else if (c == 1) ew = {wdat[15:8], wdat[15:8]};
      else ew = {wdat[7:0], wdat[7:0]};
      w = (maxwait > 0) ? $urandom_range(0, maxwait) : 0;
      for (int k = 0; k <= w; k++) begin
        string t2;
        t2 = (k > 0) ? "R9" : tg;
        chk(t2, {31'd0, bus_req}, 32'd1);
        chk(t2, {13'd0, bus_addr}, {13'd0, ea});
        chk(t2, {31'd0, bus_a0}, (c == 0) ? {31'd0, a[0]} : 32'd0);
        chk(t2, {31'd0, bus_bhe_n}, (c == 1) ? 32'd1 : ((wd || a[0]) ? 32'd0 : 32'd1));
        chk("R6", {31'd0, bus_we}, {31'd0, wr});
        if (wr) chk("R6", {16'd0, bus_wdata}, {16'd0, ew});
        if (hold) begin
          chk("R11", {31'd0, hold_ack}, 32'd0);
          chk("R11", {31'd0, busy}, 32'd1);
        end
        if (k == w) begin
          bus_rdy = 1'b1;
          bus_rdata = {mem_byte({bus_addr, 1'b1}), mem_byte({bus_addr, 1'b0})};
        end
        @(negedge clk);
        bus_rdy = 1'b0;
      end
    end
    chk("R7", {31'd0, done}, 32'd1);
    if (!wr) begin
      chk(tg, {16'd0, rdata}, {16'd0, exp_read(wd, a)});
      last_rd = exp_read(wd, a);
    end else begin
      chk("R7", {16'd0, rdata}, {16'd0, last_rd});
    end
    @(negedge clk);
    chk("R7", {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; bus_rdy = 1'b0; bus_rdata = '0; hold_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, bus_req}, 32'd0);
    chk("R1", {31'd0, busy}, 32'd0);
    chk("R1", {31'd0, done}, 32'd0);
    chk("R1", {31'd0, hold_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, req_ready}, 32'd1);

    run(0, 0, 20'h01234, 16'h0, 0, 0, "R2");
    run(0, 0, 20'h01235, 16'h0, 2, 0, "R3");
    run(0, 1, 20'h0A0B0, 16'h0, 0, 0, "R4");
    run(0, 1, 20'h0A0B1, 16'h0, 3, 0, "R5");
    run(1, 0, 20'h00010, 16'hBEEF, 0, 0, "R6");
    run(1, 0, 20'h00011, 16'hBEEF, 1, 0, "R6");
    run(1, 1, 20'h00020, 16'hCAFE, 0, 0, "R6");
    run(1, 1, 20'h00023, 16'h1357, 2, 0, "R6");
    run(0, 1, 20'hFFFFF, 16'h0, 1, 0, "R13");
    run(1, 1, 20'hFFFFF, 16'hA5C3, 0, 0, "R13");

    // R10: grant from idle, request ignored while granted
    @(negedge clk);
    hold_req = 1'b1;
    @(negedge clk);
    chk("R10", {31'd0, hold_ack}, 32'd1);
    chk("R10", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_word = 1'b0; req_write = 1'b0; req_addr = 20'h00042;
    @(negedge clk);
    chk("R10", {31'd0, bus_req}, 32'd0);
    req_valid = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk("R10", {31'd0, hold_ack}, 32'd0);
    chk("R10", {31'd0, req_ready}, 32'd1);

    // R12 and R11: hold raised with a split word in the same cycle
    run(0, 1, 20'h03457, 16'h0, 2, 1, "R12");
    chk("R12", {31'd0, hold_ack}, 32'd1);
    req_valid = 1'b1; req_word = 1'b1; req_write = 1'b0; req_addr = 20'h00100;
    @(negedge clk);
    chk("R10", {31'd0, busy}, 32'd0);
    req_valid = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk("R10", {31'd0, hold_ack}, 32'd0);

    for (int i = 0; i < 200; i++) begin
      bit wr, wd;
      logic [19:0] a;
      logic [15:0] d;
      wr = 1'($urandom_range(0, 1));
      wd = 1'($urandom_range(0, 1));
      a  = 20'($urandom);
      d  = 16'($urandom);
      run(wr, wd, a, d, 3, 1'($urandom_range(0, 3) == 0), "");
      if (hold_req) begin
        hold_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule